// File: doc/BRIEF.md
# Run-Length Escape Encoder

The block compresses a byte stream. It replaces runs of a repeated byte with a three-byte group made of the escape code, the run length and the byte itself. The escape code 8'h1B cannot stand alone in the output, so every run of escape bytes is also sent as a group, even a run of one. A run stays pending inside the block until something closes it. A different byte, a byte that would pass the run's cap, or a flush request closes the run.

Encoded bytes enter an internal FIFO whose depth is set by a parameter. A pacer takes them out one at a time. Each output byte is marked by a one-cycle pulse on `data_valid`, with at least one low cycle between pulses.

The input follows valid/ready rules. `in_ready` is high exactly when the FIFO has room for a worst-case group of three bytes. A byte is consumed in a cycle where `in_valid` and `in_ready` are both high and `flush` is low. `flush` uses the same `in_ready` as its handshake. The sender must hold `in_valid`, `in_byte` and `flush` steady until they are taken.

Top module: `rle_esc_encoder`

## Requirements
- R1: The escape code is 8'h1B. A run of 1 to 6 escape bytes is emitted as 1B, n, 1B, so an unescaped 1B never appears in the output.
- R2: A run of 3, 4 or 5 copies of an ordinary byte c is emitted as 1B, n, c, in that order.
- R3: A run of 1 or 2 copies of an ordinary byte is emitted unchanged, one output byte per input byte.
- R4: An ordinary run is capped at 5. The 6th copy starts a new run that is counted from 1.
- R5: An escape run is capped at 6. The 7th escape starts a new escape run that is counted from 1.
- R6: A pending run is closed and encoded when a different byte is taken, or when `flush` is taken. A taken `flush` takes precedence over `in_valid` in the same cycle, and the byte on `in_byte` is not consumed in that cycle.
- R7: `data_valid` is high for exactly one cycle per output byte and low for at least one cycle between bytes. Bytes appear in encoding order. `out_byte` holds its value while `data_valid` is low.
- R8: `in_ready` is high exactly when the FIFO has at least 3 free entries. A byte is taken only when `in_valid`, `in_ready` are high and `flush` is low. A flush acts only while `in_ready` is high. The FIFO never overflows.
- R9: The synchronous active-high reset empties the FIFO and discards any pending run. In the cycle after reset, `data_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| in_ready | output | 1 | Room for a worst-case group; handshake for both bytes and flush |
| flush | input | 1 | Close and encode the pending run |
| out_byte | output | 8 | Encoded output byte |
| data_valid | output | 1 | One-cycle pulse marking each output byte |

## Verification
The bench goes after runs that sit exactly at each cap and one past it. A design that split ordinary runs at 6 or escape runs at 5 would emit a wrong count byte or an extra group. A lone escape byte must come out as a full group; a design that treated escapes like ordinary bytes would leak a bare 1B. Flushes are issued in the middle of a run, and once while a byte is also offered. A design that ignored the precedence would drop or duplicate that byte. A long unbroken stream keeps the FIFO near full, so a wrong free-space threshold shows up as a lost byte or an `in_ready` mismatch. A reset issued while a run is pending must leave nothing behind to flush.

// File: rtl/rle_esc_pkg.sv
package rle_esc_pkg;
  localparam logic [7:0] ESC_CODE = 8'h1B;
  localparam int LIT_CAP  = 5;
  localparam int ESC_CAP  = 6;
  localparam int GRP_MAX  = 3;
  localparam int CNT_W    = $clog2(ESC_CAP + 1);
  localparam int LEN_W    = $clog2(GRP_MAX + 1);

  typedef struct packed {
    logic [LEN_W-1:0]          len;
    logic [GRP_MAX-1:0][7:0]   bytes;  // bytes[0] leaves first
  } grp_t;

  function automatic logic [CNT_W-1:0] cap_of(input logic [7:0] b);
    return (b == ESC_CODE) ? CNT_W'(ESC_CAP) : CNT_W'(LIT_CAP);
  endfunction

  function automatic grp_t encode_run(input logic [7:0] b, input logic [CNT_W-1:0] n);
    grp_t g;
    g = '0;
    if (b == ESC_CODE || n >= CNT_W'(3)) begin
      g.len      = LEN_W'(3);
      g.bytes[0] = ESC_CODE;
      g.bytes[1] = 8'(n);
      g.bytes[2] = b;
    end else if (n == CNT_W'(2)) begin
      g.len      = LEN_W'(2);
      g.bytes[0] = b;
      g.bytes[1] = b;
    end else if (n == CNT_W'(1)) begin
      g.len      = LEN_W'(1);
      g.bytes[0] = b;
    end
    return g;
  endfunction
endpackage

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_esc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       take_byte,
  input  logic       take_flush,
  input  logic [7:0] in_byte,
  output grp_t       grp
);
  logic             run_on;
  logic [7:0]       run_byte;
  logic [CNT_W-1:0] run_cnt;
  logic             extend;
  logic             closing;

  always_comb begin
    extend  = run_on && (in_byte == run_byte) && (run_cnt < cap_of(run_byte));
    closing = take_flush ? run_on : (take_byte && run_on && !extend);
    grp     = closing ? encode_run(run_byte, run_cnt) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_on   <= 1'b0;
      run_byte <= '0;
      run_cnt  <= '0;
    end else if (take_flush) begin
      run_on  <= 1'b0;
      run_cnt <= '0;
    end else if (take_byte) begin
      if (extend) begin
        run_cnt <= run_cnt + CNT_W'(1);
      end else begin
        run_on   <= 1'b1;
        run_byte <= in_byte;
        run_cnt  <= CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rle_multi_fifo.sv
module rle_multi_fifo #(
  parameter  int DEPTH  = 8,
  parameter  int W      = 8,
  parameter  int LANES  = 3,
  localparam int PTR_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1),
  localparam int LN_W   = $clog2(LANES + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LN_W-1:0]           wr_n,
  input  logic [LANES-1:0][W-1:0]   wr_data,
  input  logic                      rd,
  output logic [W-1:0]              head,
  output logic                      empty,
  output logic [FILL_W-1:0]         fill
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;

  assign head  = mem[rd_ptr];
  assign empty = (fill == '0);

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (!rst && i < int'(wr_n)) mem[wr_ptr + PTR_W'(i)] <= wr_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr + PTR_W'(wr_n);
      if (rd) rd_ptr <= rd_ptr + PTR_W'(1);
      fill <= fill + FILL_W'(wr_n) - FILL_W'(rd);
    end
  end
endmodule

// File: rtl/rle_out_pacer.sv
module rle_out_pacer (
  input  logic       clk,
  input  logic       rst,
  input  logic       empty,
  input  logic [7:0] head,
  output logic       rd,
  output logic [7:0] out_byte,
  output logic       data_valid
);
  assign rd = !empty && !data_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_valid <= 1'b0;
      out_byte   <= '0;
    end else begin
      data_valid <= rd;
      if (rd) out_byte <= head;
    end
  end
endmodule

// File: rtl/rle_esc_encoder.sv
module rle_esc_encoder
  import rle_esc_pkg::*;
#(
  parameter  int DEPTH  = 8,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       in_ready,
  input  logic       flush,
  output logic [7:0] out_byte,
  output logic       data_valid
);
  logic [FILL_W-1:0] fifo_fill;
  logic              fifo_empty;
  logic [7:0]        fifo_head;
  logic              fifo_rd;
  logic              take_byte;
  logic              take_flush;
  grp_t              grp;

  assign in_ready   = (fifo_fill <= FILL_W'(DEPTH - GRP_MAX));
  assign take_flush = flush && in_ready;
  assign take_byte  = in_valid && in_ready && !flush;

  rle_run_tracker u_tracker (
    .clk        (clk),
    .rst        (rst),
    .take_byte  (take_byte),
    .take_flush (take_flush),
    .in_byte    (in_byte),
    .grp        (grp)
  );

  rle_multi_fifo #(.DEPTH(DEPTH), .W(8), .LANES(GRP_MAX)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_n    (grp.len),
    .wr_data (grp.bytes),
    .rd      (fifo_rd),
    .head    (fifo_head),
    .empty   (fifo_empty),
    .fill    (fifo_fill)
  );

  rle_out_pacer u_pacer (
    .clk        (clk),
    .rst        (rst),
    .empty      (fifo_empty),
    .head       (fifo_head),
    .rd         (fifo_rd),
    .out_byte   (out_byte),
    .data_valid (data_valid)
  );
endmodule

// File: rtl/rle_esc_encoder_props.sv
module rle_esc_encoder_props #(
  parameter  int DEPTH  = 8,
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              data_valid,
  input logic [7:0]        out_byte,
  input logic [FILL_W-1:0] fill
);
  AST_DV_SINGLE: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!data_valid && !$past(rst)) |-> $stable(out_byte)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fill == '0 && !data_valid) |=> !data_valid); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(DEPTH)); // R8

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!data_valid && in_ready)); // R9
endmodule

bind rle_esc_encoder rle_esc_encoder_props #(.DEPTH(DEPTH)) u_props (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .data_valid (data_valid),
  .out_byte   (out_byte),
  .fill       (fifo_fill)
);

// File: tb/rle_esc_encoder_test.sv
module rle_esc_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam logic [7:0] ESC = 8'h1B;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       flush = 1'b0;
  logic       in_ready;
  logic [7:0] out_byte;
  logic       data_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  rle_esc_encoder #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .flush(flush), .out_byte(out_byte), .data_valid(data_valid)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit saw_stall = 0;
  int cyc = 0;
  logic [7:0] got[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // behavioural reference: queue of encoded bytes, pending run, pacer state
  logic [7:0] mq[$];
  bit         m_on = 0;
  logic [7:0] m_b = '0;
  int         m_cnt = 0;
  bit         m_dv = 0;
  logic [7:0] m_ob = '0;

  function automatic void m_close();
    if (m_on) begin
      if (m_b == ESC || m_cnt >= 3) begin
        mq.push_back(ESC); mq.push_back(8'(m_cnt)); mq.push_back(m_b);
      end else begin
        for (int k = 0; k < m_cnt; k++) mq.push_back(m_b);
      end
    end
    m_on = 0;
    m_cnt = 0;
  endfunction

  function automatic void m_take(logic [7:0] b);
    int cap;
    cap = (b == ESC) ? 6 : 5;
    if (m_on && b == m_b && m_cnt < cap) m_cnt++;
    else begin
      m_close();
      m_on = 1; m_b = b; m_cnt = 1;
    end
  endfunction

  always @(posedge clk) begin
    bit sp;
    cyc++;
    if (rst) begin
      mq.delete(); m_on = 0; m_cnt = 0; m_dv = 0; m_ob = '0;
    end else begin
      sp = (DEPTH - mq.size()) >= 3;
      if (!m_dv && mq.size() > 0) begin m_ob = mq.pop_front(); m_dv = 1; end
      else m_dv = 0;
      if (sp && flush) m_close();
      else if (sp && in_valid) m_take(in_byte);
    end
    if (cyc == 150000 && !done) begin
      chk(0, "watchdog", cyc, 0);
      finish_up();
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(data_valid == m_dv, "R7 data_valid", data_valid, m_dv);
      if (m_dv) chk(out_byte == m_ob, "R7 out_byte order", out_byte, m_ob);
      chk(in_ready == ((DEPTH - mq.size()) >= 3), "R8 in_ready", in_ready, (DEPTH - mq.size()) >= 3);
      if (data_valid) got.push_back(out_byte);
      if (!in_ready) saw_stall = 1;
    end
  end

  task automatic send(logic [7:0] b);
    in_valid = 1; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic do_flush();
    flush = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    flush = 0;
  endtask

  task automatic drain_and_compare(string req, logic [7:0] exp[$]);
    repeat (40) @(negedge clk);
    chk(got.size() == exp.size(), {req, " length"}, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      chk(got[i] == exp[i], req, got[i], exp[i]);
    got.delete();
  endtask

  task automatic scen(string req, logic [7:0] ins[$], logic [7:0] exp[$]);
    foreach (ins[i]) send(ins[i]);
    do_flush();
    drain_and_compare(req, exp);
  endtask

  initial begin
    logic [7:0] ins[$];
    logic [7:0] exp[$];
    repeat (3) @(negedge clk);
    rst = 0;
    chk(data_valid == 0, "R9 reset data_valid", data_valid, 0);
    chk(in_ready == 1, "R9 reset in_ready", in_ready, 1);

    scen("R3 pass-through ab", '{8'h61, 8'h62}, '{8'h61, 8'h62});
    scen("R3 pair", '{8'h63, 8'h63, 8'h64}, '{8'h63, 8'h63, 8'h64});
    scen("R2 run of 3", '{8'h61, 8'h61, 8'h61, 8'h62}, '{ESC, 8'h03, 8'h61, 8'h62});
    scen("R2 run of 5", '{8'h71, 8'h71, 8'h71, 8'h71, 8'h71}, '{ESC, 8'h05, 8'h71});
    scen("R4 run of 6", '{8'h61, 8'h61, 8'h61, 8'h61, 8'h61, 8'h61},
         '{ESC, 8'h05, 8'h61, 8'h61});
    scen("R4 run of 8", '{8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20, 8'h20},
         '{ESC, 8'h05, 8'h20, ESC, 8'h03, 8'h20});
    scen("R1 single escape", '{ESC}, '{ESC, 8'h01, ESC});
    scen("R1 escape pair then a", '{ESC, ESC, 8'h61}, '{ESC, 8'h02, ESC, 8'h61});
    ins.delete(); for (int i = 0; i < 6; i++) ins.push_back(ESC);
    scen("R1 six escapes", ins, '{ESC, 8'h06, ESC});
    ins.delete(); for (int i = 0; i < 8; i++) ins.push_back(ESC);
    scen("R5 eight escapes", ins, '{ESC, 8'h06, ESC, ESC, 8'h02, ESC});

    // R6: flush splits a run in two
    send(8'h61); send(8'h61); do_flush();
    send(8'h61); send(8'h61); send(8'h61); do_flush();
    drain_and_compare("R6 flush mid-run", '{8'h61, 8'h61, ESC, 8'h03, 8'h61});

    // R6: flush and a valid byte in the same cycle; flush wins, byte taken later
    send(8'h79); send(8'h79);
    in_valid = 1; in_byte = 8'h7A; flush = 1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    flush = 0;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
    do_flush();
    drain_and_compare("R6 flush precedence", '{8'h79, 8'h79, 8'h7A});

    // R9: reset discards a pending run
    send(8'h61); send(8'h61); send(8'h61);
    rst = 1; @(negedge clk); rst = 0;
    chk(in_ready == 1, "R9 ready after reset", in_ready, 1);
    do_flush();
    exp.delete();
    drain_and_compare("R9 pending run dropped", exp);

    // R8: long unbroken stream keeps the queue under pressure
    saw_stall = 0;
    for (int i = 0; i < 90; i++) begin
      int ph;
      ph = i % 13;
      send(ph < 7 ? ESC : (ph < 10 ? 8'h61 + 8'(i % 3) : 8'h6A));
    end
    do_flush();
    repeat (60) @(negedge clk);
    got.delete();
    chk(saw_stall, "R8 back-pressure seen", saw_stall, 1);

    finish_up();
  end
endmodule